// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This execution unit sits in the datapath of a 32-bit CPU. It recognises one class of multiply-accumulate instruction. For each operand it picks the upper or lower 16-bit half of a 32-bit source register. It multiplies the two halves as signed numbers, adds a signed 32-bit accumulator and returns the wrapped 32-bit sum together with a destination register index.

The surrounding pipeline supplies the instruction word and the three register values already read from the register file, qualified by a valid strobe. One clock later the unit presents a one-cycle write enable, the destination index and the result. It also keeps a sticky overflow flag. An accumulate that overflows as a signed 32-bit addition sets the flag, and only reset clears it. The condition field, hazards and all other instructions are handled elsewhere.

Top module: `hmacUnit`

## Requirements
- R1: An instruction is accepted when `instrValid` is high, `instrWord[27:20]` equals 8'h10, bit 7 is 1 and bit 4 is 0. Bits [31:28] have no effect on acceptance.
- R2: Bit 5 of the instruction selects the half of `srcA`, and bit 6 selects the half of `srcB`. In both cases 0 picks bits [15:0] and 1 picks bits [31:16].
- R3: Both selected halves are sign-extended before multiplying. For example, 16'h8000 times 16'h8000 gives 32'h4000_0000.
- R4: `wrData` is the low 32 bits of the product plus `srcAcc`, with `srcAcc` taken as signed. The sum wraps and is not saturated.
- R5: `qFlag` becomes 1 after an accepted instruction whose signed 32-bit accumulate overflows, in either the positive or the negative direction.
- R6: Once set, `qFlag` stays 1 through later operations that do not overflow, and through rejected or idle cycles, until reset.
- R7: An accepted instruction on clock edge N gives `wrEn` = 1 for exactly the cycle after edge N, with `wrIdx` = `instrWord[19:16]`. Back-to-back accepted instructions keep `wrEn` high.
- R8: A cycle with no accepted instruction drives `wrEn` low on the next edge and leaves `wrData`, `wrIdx` and `qFlag` unchanged.
- R9: Synchronous reset sets `wrEn`, `wrIdx`, `wrData` and `qFlag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instrValid | input | 1 | Instruction word and operands are valid this cycle |
| instrWord | input | 32 | Instruction word |
| srcA | input | 32 | Register value for the first multiplicand (index in bits [3:0]) |
| srcB | input | 32 | Register value for the second multiplicand (index in bits [11:8]) |
| srcAcc | input | 32 | Register value for the accumulator (index in bits [15:12]) |
| wrEn | output | 1 | Destination write enable, one cycle per accepted instruction |
| wrIdx | output | 4 | Destination register index |
| wrData | output | 32 | Wrapped multiply-accumulate result |
| qFlag | output | 1 | Sticky accumulate overflow flag |

## Verification
The assertions assume that `rst` is a clean synchronous level and that `instrWord` and the source values are stable, known values at every rising edge once reset is released. The product range check also assumes the selected halves come only from the 32-bit sources. The bench changes every input only on the falling edge and never leaves any input undriven. The operand sets include the extreme halfword values, so the product and overflow properties are exercised at their limits.

// File: rtl/hmacPkg.sv
`timescale 1ns/1ps
package hmacPkg;
  localparam int DATA_W  = 32;
  localparam int HALF_W  = DATA_W / 2;
  localparam int IDX_W   = 4;
  // instruction field positions that the decoder relies on
  localparam int DST_LSB  = 16;
  localparam int SELA_BIT = 5;
  localparam int SELB_BIT = 6;
  localparam logic [7:0] CLASS_HI = 8'h10;  // expected value of bits [27:20]

  // strobes from control to datapath
  typedef struct packed {
    logic             issue;
    logic             hiA;
    logic             hiB;
    logic [IDX_W-1:0] dst;
  } hmacCmd_t;
endpackage

// File: rtl/hmacCtrl.sv
`timescale 1ns/1ps
module hmacCtrl
  import hmacPkg::*;
(
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  output hmacCmd_t          cmd
);
  logic isClass;

  // R1: class match; the condition nibble [31:28] is not examined
  always_comb begin
    isClass = (instrWord[27:20] == CLASS_HI) && instrWord[7] && !instrWord[4];
    cmd.issue = instrValid && isClass;
    cmd.hiA   = instrWord[SELA_BIT];
    cmd.hiB   = instrWord[SELB_BIT];
    cmd.dst   = instrWord[DST_LSB +: IDX_W];
  end
endmodule

// File: rtl/hmacDatapath.sv
`timescale 1ns/1ps
module hmacDatapath
  import hmacPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  hmacCmd_t          cmd,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcAcc,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              qFlag
);
  logic [1:0][DATA_W-1:0] srcPair;
  logic [1:0]             selHi;
  logic [1:0][HALF_W-1:0] halfSel;

  logic signed [DATA_W-1:0] prod;
  logic signed [DATA_W-1:0] sum;
  logic                     addOvf;

  assign srcPair = {srcB, srcA};
  assign selHi   = {cmd.hiB, cmd.hiA};

  // R2: per-operand halfword pick
  for (genvar g = 0; g < 2; g++) begin : gHalf
    assign halfSel[g] = selHi[g] ? srcPair[g][DATA_W-1:HALF_W] : srcPair[g][HALF_W-1:0];
  end

  // R3/R4/R5: signed multiply, wrapping add, overflow from the operand and sum signs
  always_comb begin
    prod   = $signed(halfSel[0]) * $signed(halfSel[1]);
    sum    = prod + $signed(srcAcc);
    addOvf = (prod[DATA_W-1] == srcAcc[DATA_W-1]) && (sum[DATA_W-1] != prod[DATA_W-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrEn   <= 1'b0;
      wrIdx  <= '0;
      wrData <= '0;
      qFlag  <= 1'b0;
    end else begin
      wrEn <= cmd.issue;
      if (cmd.issue) begin
        wrIdx  <= cmd.dst;
        wrData <= sum;
        qFlag  <= qFlag | addOvf;
      end
    end
  end

  // R3: a 16x16 signed product always fits the range -(2^30 - 2^15) .. 2^30
  a_r3_prod_range: assert property (@(posedge clk) disable iff (rst)
    cmd.issue |-> (prod <= 32'sh4000_0000 && prod >= -32'sh3FFF_8000));

  // R6: the flag never falls outside reset
  a_r6_q_sticky: assert property (@(posedge clk) disable iff (rst)
    qFlag |=> qFlag);

  // R5: the flag rises only after an accepted instruction
  a_r5_q_rise_on_issue: assert property (@(posedge clk) disable iff (rst)
    $rose(qFlag) |-> $past(cmd.issue));

  // R7: write enable follows the control strobe by one cycle
  a_r7_wr_follows_issue: assert property (@(posedge clk) disable iff (rst)
    cmd.issue |=> wrEn);

  // R8: idle cycles drop the enable and hold the result
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !cmd.issue |=> (!wrEn && $stable(wrData) && $stable(wrIdx) && $stable(qFlag)));
endmodule

// File: rtl/hmacUnit.sv
`timescale 1ns/1ps
module hmacUnit
  import hmacPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] srcAcc,
  output logic              wrEn,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              qFlag
);
  hmacCmd_t cmd;

  hmacCtrl ctrl_i (
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .cmd        (cmd)
  );

  hmacDatapath dp_i (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .srcA   (srcA),
    .srcB   (srcB),
    .srcAcc (srcAcc),
    .wrEn   (wrEn),
    .wrIdx  (wrIdx),
    .wrData (wrData),
    .qFlag  (qFlag)
  );

  // R9: nothing is written in the cycle after reset
  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> !wrEn && !qFlag);
endmodule

// File: tb/hmacUnit_tb.sv
`timescale 1ns/1ps
module hmacUnit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        instrValid;
  logic [31:0] instrWord, srcA, srcB, srcAcc;
  logic        wrEn;
  logic [3:0]  wrIdx;
  logic [31:0] wrData;
  logic        qFlag;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  // reference state
  bit          expWe;
  logic [3:0]  expIdx;
  logic [31:0] expData;
  bit          expQ;

  always #5 clk = ~clk;

  hmacUnit dut_i (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instrWord(instrWord),
    .srcA(srcA), .srcB(srcB), .srcAcc(srcAcc),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .qFlag(qFlag)
  );

  function automatic logic [31:0] mkInstr(input logic [3:0] cond, input bit x, input bit y,
                                          input logic [3:0] rd, input logic [3:0] rn,
                                          input logic [3:0] rs, input logic [3:0] rm);
    return {cond, 8'h10, rd, rn, rs, 1'b1, y, x, 1'b0, rm};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(wrEn == expWe,     tag, "wrEn",   wrEn,   expWe);
    chk(wrIdx == expIdx,   tag, "wrIdx",  wrIdx,  expIdx);
    chk(wrData == expData, tag, "wrData", wrData, expData);
    chk(qFlag == expQ,     tag, "qFlag",  qFlag,  expQ);
  endtask

  // drive at the falling edge, update the model, compare at the next falling edge
  task automatic step(input bit v, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] acc, input string tag);
    shortint ha, hb;
    longint  s;
    bit      accept;
    instrValid = v; instrWord = ins; srcA = a; srcB = b; srcAcc = acc;
    accept = v && (ins[27:20] == 8'h10) && ins[7] && !ins[4];
    if (rst) begin
      expWe = 0; expIdx = 0; expData = 0; expQ = 0;
    end else begin
      expWe = accept;
      if (accept) begin
        ha = ins[5] ? shortint'(a[31:16]) : shortint'(a[15:0]);
        hb = ins[6] ? shortint'(b[31:16]) : shortint'(b[15:0]);
        s  = longint'(int'(ha) * int'(hb)) + longint'(int'(acc));
        if (s > 64'sd2147483647 || s < -64'sd2147483648) expQ = 1;
        expData = s[31:0];
        expIdx  = ins[19:16];
      end
    end
    @(posedge clk);
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a4, b4;
    rst = 1; instrValid = 0; instrWord = 0; srcA = 0; srcB = 0; srcAcc = 0;
    @(negedge clk);
    step(1, mkInstr(4'hE, 0, 0, 4'd3, 4'd1, 4'd2, 4'd0), 32'h1234_5678, 32'h0002_0003, 32'd5, "R9");
    rst = 0;

    // R2 four select combinations: a = {-2, 3}, b = {5, -7}
    a4 = 32'hFFFE_0003; b4 = 32'h0005_FFF9;
    step(1, mkInstr(4'hE, 0, 0, 4'd1, 4'd0, 4'd0, 4'd0), a4, b4, 32'd100, "R2");
    step(1, mkInstr(4'hE, 1, 0, 4'd2, 4'd0, 4'd0, 4'd0), a4, b4, 32'd100, "R2");
    step(1, mkInstr(4'hE, 0, 1, 4'd4, 4'd0, 4'd0, 4'd0), a4, b4, 32'd100, "R2");
    step(1, mkInstr(4'hE, 1, 1, 4'd8, 4'd0, 4'd0, 4'd0), a4, b4, 32'd100, "R2");
    step(0, 32'h0, a4, b4, 32'd100, "R7");

    // R3 most negative halves
    step(1, mkInstr(4'hE, 1, 0, 4'd5, 4'd0, 4'd0, 4'd0), 32'h8000_1111, 32'h2222_8000, 32'd0, "R3");
    // R4 negative result, wraps through zero without overflow
    step(1, mkInstr(4'hE, 0, 0, 4'd6, 4'd0, 4'd0, 4'd0), 32'h0000_0010, 32'h0000_FFFF, 32'd3, "R4");

    // R1 other condition nibble still accepted
    step(1, mkInstr(4'h0, 0, 1, 4'd7, 4'd0, 4'd0, 4'd0), 32'h0000_7FFF, 32'h7FFF_0000, 32'hFFFF_0000, "R1");

    // R8 rejected forms: bit4 set, wrong class byte, valid low
    step(1, mkInstr(4'hE, 0, 0, 4'd9, 4'd0, 4'd0, 4'd0) | 32'h10, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, "R8");
    step(1, mkInstr(4'hE, 0, 0, 4'd9, 4'd0, 4'd0, 4'd0) ^ 32'h0100_0000, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, "R8");
    step(0, mkInstr(4'hE, 0, 0, 4'd9, 4'd0, 4'd0, 4'd0), 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF, "R8");

    // R5 positive overflow: 2^30 + 0x7FFF0000
    step(1, mkInstr(4'hE, 0, 0, 4'd10, 4'd0, 4'd0, 4'd0), 32'h0000_8000, 32'h0000_8000, 32'h7FFF_0000, "R5");
    // R6 later non-overflowing op keeps the flag
    step(1, mkInstr(4'hE, 0, 0, 4'd11, 4'd0, 4'd0, 4'd0), 32'h0000_0002, 32'h0000_0003, 32'd1, "R6");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R6");

    // R9 reset clears the flag, then R5 negative overflow
    rst = 1;
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R9");
    rst = 0;
    step(1, mkInstr(4'hE, 0, 0, 4'd12, 4'd0, 4'd0, 4'd0), 32'h0000_0001, 32'h0000_0001, 32'd7, "R6");
    step(1, mkInstr(4'hE, 0, 0, 4'd13, 4'd0, 4'd0, 4'd0), 32'h0000_8000, 32'h0000_7FFF, 32'h8000_0000, "R5");
    step(1, mkInstr(4'hE, 1, 1, 4'd14, 4'd0, 4'd0, 4'd0), 32'h0003_0000, 32'h0004_0000, 32'd0, "R6");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, "R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule